// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a synchronous on-chip client reach an external asynchronous static RAM with a 20-bit address and an 8-bit data path. The client offers one access at a time on a valid/ready port; the controller turns each access into a timed sequence on the memory's two chip selects, output enable and write enable. It also decides when the shared data bus is driven from the chip side, using a separate output value and an output-enable control for the pad.

Every nanosecond limit of the memory is taken from a speed-grade table selected by a parameter, the 55 ns grade or the 70 ns grade. Each limit becomes a cycle count, rounded up against the system clock period parameter with a floor of one cycle. A write is the interval in which the low-active select is low, the high-active select is high and write enable is low. A read holds output enable low until the slowest access path has elapsed. After a read, a turnaround gap gives the memory time to release the bus before the controller may drive it.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, mem_cs1_n, mem_we_n and mem_oe_n are 1, mem_cs2 is 0, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: The two chip selects always move together (mem_cs1_n = 0 exactly when mem_cs2 = 1), and the memory is deselected in every cycle in which req_ready is 1.
- R3: After a write is accepted (req_write = 1), both selects are active with mem_we_n = 0 from the next cycle for exactly P cycles, where P is the largest of the rounded write-pulse, address-to-end, select-to-end and data-setup limits. mem_addr and mem_dq_out stay constant for the whole window.
- R4: From the acceptance of a write, req_ready returns to 1 after max(P + 1, rounded write-cycle limit) cycles, so that consecutive selection windows are never closer than the write-cycle limit.
- R5: mem_dq_oe is 1 exactly during the write-enable window plus the single cycle after it, and mem_oe_n stays 1 during that time.
- R6: After a read is accepted (req_write = 0), both selects are active with mem_oe_n = 0 and mem_we_n = 1 for exactly Q cycles, where Q is the largest of the rounded address-access, select-access and output-enable-access limits. The bus value present at the end of the Q-th cycle is returned on rsp_rdata together with a one-cycle rsp_valid pulse in the following cycle.
- R7: After a read, req_ready stays 0 for H more cycles, H being the rounded bus-release limit. mem_dq_oe is therefore never 1 while the memory may still drive the bus.
- R8: A request is taken only in a cycle with req_valid = 1 and req_ready = 1. While busy, changes on req_addr, req_wdata, req_write and req_valid have no effect on the access in progress.
- R9: SPEED_GRADE = 0 selects the 55 ns limits (cycle 55, write pulse 40, address/select to end 45, data setup 25, access 55, OE access 25, release 20). SPEED_GRADE = 1 selects 70/50/60/60/30/70/35/25. Each limit becomes ceil(ns / CLK_PERIOD_NS) cycles, and never less than one.
- R10: mem_addr shows the address of the most recently accepted request from the first cycle of its selection window until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Client offers an access |
| req_ready | output | 1 | Controller is idle and takes the offered access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Memory word address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Byte returned by a read |
| mem_addr | output | ADDR_W | Address pins of the memory |
| mem_cs1_n | output | 1 | Low-active chip select |
| mem_cs2 | output | 1 | High-active chip select |
| mem_oe_n | output | 1 | Output enable, low active |
| mem_we_n | output | 1 | Write enable, low active |
| mem_dq_out | output | DATA_W | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Pad driver enable for the data bus |
| mem_dq_in | input | DATA_W | Value sampled from the data bus |

## Verification
The hardest case to reach is a write that starts right after the read turnaround, at the earliest cycle the controller allows: the driver then switches on just as the memory's release window closes. The stimulus keeps req_valid high with the next request already queued, so every access is accepted on the first ready cycle. A behavioural memory tracks the time since output enable rose, and it would report contention or a short access on any cycle lost or gained. Two lanes run the same sequence, one on the 55 ns grade with a 5 ns clock, where a write needs a padding cycle, and one on the 70 ns grade with a 10 ns clock, where it does not.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_WHOLD,
    ST_WPAD,
    ST_READ,
    ST_RTURN
  } seq_state_t;

  localparam int LIM_CYCLE   = 0;
  localparam int LIM_WPULSE  = 1;
  localparam int LIM_ADDR_WE = 2;
  localparam int LIM_SEL_WE  = 3;
  localparam int LIM_DSETUP  = 4;
  localparam int LIM_ACCESS  = 5;
  localparam int LIM_OE_ACC  = 6;
  localparam int LIM_RELEASE = 7;

  function automatic int limit_ns(input int grade, input int which);
    int v;
    case (which)
      LIM_CYCLE:   v = (grade == 0) ? 55 : 70;
      LIM_WPULSE:  v = (grade == 0) ? 40 : 50;
      LIM_ADDR_WE: v = (grade == 0) ? 45 : 60;
      LIM_SEL_WE:  v = (grade == 0) ? 45 : 60;
      LIM_DSETUP:  v = (grade == 0) ? 25 : 30;
      LIM_ACCESS:  v = (grade == 0) ? 55 : 70;
      LIM_OE_ACC:  v = (grade == 0) ? 25 : 35;
      default:     v = (grade == 0) ? 20 : 25;
    endcase
    return v;
  endfunction

  function automatic int to_cycles(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int WR_PULSE = 5,
  parameter int WR_PAD   = 0,
  parameter int RD_CYC   = 6,
  parameter int TURN_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic rd_done,
  output logic cs1_n,
  output logic cs2,
  output logic oe_n,
  output logic we_n,
  output logic dq_oe
);

  localparam int CMAX  = max2(max2(WR_PULSE, WR_PAD), max2(RD_CYC, TURN_CYC));
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam int RUN_W = CNT_W + 2;
  localparam int GAP_LIM = TURN_CYC + 1;

  seq_state_t state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;

  assign accept = req_ready && req_valid;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    rd_done = 1'b0;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          if (req_write) begin
            state_n = ST_WRITE;
            cnt_n   = CNT_W'(WR_PULSE - 1);
          end else begin
            state_n = ST_READ;
            cnt_n   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_WRITE: begin
        if (cnt == '0) state_n = ST_WHOLD;
        else cnt_n = cnt - CNT_W'(1);
      end
      ST_WHOLD: begin
        if (WR_PAD > 0) begin
          state_n = ST_WPAD;
          cnt_n   = CNT_W'(WR_PAD - 1);
        end else begin
          state_n = ST_IDLE;
        end
      end
      ST_WPAD: begin
        if (cnt == '0) state_n = ST_IDLE;
        else cnt_n = cnt - CNT_W'(1);
      end
      ST_READ: begin
        if (cnt == '0) begin
          state_n = ST_RTURN;
          cnt_n   = CNT_W'(TURN_CYC - 1);
          rd_done = 1'b1;
        end else begin
          cnt_n = cnt - CNT_W'(1);
        end
      end
      ST_RTURN: begin
        if (cnt == '0) state_n = ST_IDLE;
        else cnt_n = cnt - CNT_W'(1);
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // strobes are registered straight from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      req_ready <= 1'b1;
      cs1_n     <= 1'b1;
      cs2       <= 1'b0;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      dq_oe     <= 1'b0;
    end else begin
      state     <= state_n;
      cnt       <= cnt_n;
      req_ready <= (state_n == ST_IDLE);
      cs1_n     <= !(state_n == ST_WRITE || state_n == ST_READ);
      cs2       <=  (state_n == ST_WRITE || state_n == ST_READ);
      oe_n      <= !(state_n == ST_READ);
      we_n      <= !(state_n == ST_WRITE);
      dq_oe     <=  (state_n == ST_WRITE || state_n == ST_WHOLD);
    end
  end

  // watch counters for the pulse and gap assertions
  logic [RUN_W-1:0] we_run;
  logic [RUN_W-1:0] oe_gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_run <= '0;
      oe_gap <= RUN_W'(GAP_LIM);
    end else begin
      if (!we_n) we_run <= (we_run == '1) ? we_run : we_run + RUN_W'(1);
      else       we_run <= '0;
      if (!oe_n)                        oe_gap <= '0;
      else if (oe_gap < RUN_W'(GAP_LIM)) oe_gap <= oe_gap + RUN_W'(1);
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cs1_n && !cs2 && we_n && oe_n && !dq_oe && req_ready));

  assert_idle_deselect_R2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (cs1_n && !cs2));

  assert_we_width_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (we_run == RUN_W'(WR_PULSE)));

  assert_drive_window_R5: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (!we_n || $past(!we_n)));

  assert_no_read_write_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n));

  assert_turn_gap_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> (oe_gap >= RUN_W'(GAP_LIM)));

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              rd_done,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      rsp_valid <= rd_done;
      if (rd_done) rsp_rdata <= mem_dq_in;
    end
  end

  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(mem_addr) && $stable(mem_dq_out)));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int SPEED_GRADE   = 0,
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int C_CYCLE = to_cycles(limit_ns(SPEED_GRADE, LIM_CYCLE),   CLK_PERIOD_NS);
  localparam int C_WP    = to_cycles(limit_ns(SPEED_GRADE, LIM_WPULSE),  CLK_PERIOD_NS);
  localparam int C_AW    = to_cycles(limit_ns(SPEED_GRADE, LIM_ADDR_WE), CLK_PERIOD_NS);
  localparam int C_CW    = to_cycles(limit_ns(SPEED_GRADE, LIM_SEL_WE),  CLK_PERIOD_NS);
  localparam int C_DW    = to_cycles(limit_ns(SPEED_GRADE, LIM_DSETUP),  CLK_PERIOD_NS);
  localparam int C_AA    = to_cycles(limit_ns(SPEED_GRADE, LIM_ACCESS),  CLK_PERIOD_NS);
  localparam int C_OE    = to_cycles(limit_ns(SPEED_GRADE, LIM_OE_ACC),  CLK_PERIOD_NS);
  localparam int C_HZ    = to_cycles(limit_ns(SPEED_GRADE, LIM_RELEASE), CLK_PERIOD_NS);

  localparam int WR_PULSE = max2(max2(C_WP, C_AW), max2(C_CW, C_DW));
  localparam int WR_PAD   = (C_CYCLE > WR_PULSE + 1) ? (C_CYCLE - WR_PULSE - 1) : 0;
  localparam int RD_CYC   = max2(max2(C_AA, C_OE), C_CYCLE);
  localparam int TURN_CYC = C_HZ;

  logic accept;
  logic rd_done;

  sram_ctrl_seq #(
    .WR_PULSE (WR_PULSE),
    .WR_PAD   (WR_PAD),
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .rd_done   (rd_done),
    .cs1_n     (mem_cs1_n),
    .cs2       (mem_cs2),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .dq_oe     (mem_dq_oe)
  );

  sram_ctrl_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .rd_done    (rd_done),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: tb/sram_ctrl_test.sv
module sram_ctrl_lane #(
  parameter int GRADE = 0,
  parameter int TCLK  = 10
) (
  input  logic clk,
  input  logic rst,
  output logic done,
  output int   checks,
  output int   errors
);

  localparam int NS_WC = (GRADE == 0) ? 55 : 70;
  localparam int NS_WP = (GRADE == 0) ? 40 : 50;
  localparam int NS_AW = (GRADE == 0) ? 45 : 60;
  localparam int NS_DW = (GRADE == 0) ? 25 : 30;
  localparam int NS_AA = (GRADE == 0) ? 55 : 70;
  localparam int NS_OE = (GRADE == 0) ? 25 : 35;
  localparam int NS_HZ = (GRADE == 0) ? 20 : 25;

  function automatic int up(input int t);
    int c;
    c = t / TCLK;
    if (c * TCLK < t) c = c + 1;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int P    = mx(mx(up(NS_WP), up(NS_AW)), up(NS_DW));
  localparam int WBSY = mx(P + 1, up(NS_WC));
  localparam int Q    = mx(mx(up(NS_AA), up(NS_OE)), up(NS_WC));
  localparam int H    = up(NS_HZ);

  logic        req_valid, req_ready, req_write;
  logic [19:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [19:0] mem_addr;
  logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  sram_ctrl #(
    .CLK_PERIOD_NS (TCLK),
    .SPEED_GRADE   (GRADE),
    .ADDR_W        (20),
    .DATA_W        (8)
  ) uut (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_cs1_n  (mem_cs1_n),
    .mem_cs2    (mem_cs2),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in)
  );

  // reference model state: kind 0 = none, 1 = write, 2 = read; j = cycles since accept
  int          kind, j;
  logic [19:0] m_addr;
  logic [7:0]  m_data, m_exp;
  logic [7:0]  ref_mem [256];
  logic [7:0]  smem    [256];

  function automatic bit exp_ready(input int k, input int jj);
    if (k == 1) return jj >= WBSY;
    if (k == 2) return jj >= Q + H;
    return 1'b1;
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) begin
      ref_mem[i] = 8'h00;
      smem[i]    = 8'h00;
    end
    kind = 0;
    j    = 0;
  end

  always @(posedge clk) begin
    if (rst) begin
      kind = 0;
      j    = 0;
    end else if (req_valid && exp_ready(kind, j)) begin
      kind   = req_write ? 1 : 2;
      j      = 0;
      m_addr = req_addr;
      m_data = req_wdata;
      if (req_write) ref_mem[req_addr[7:0]] = req_wdata;
      else           m_exp = ref_mem[req_addr[7:0]];
    end else begin
      j = j + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s (grade %0d): actual %0h expected %0h", tag, GRADE, act, exp);
    end
  endtask

  // behavioural memory plus cycle comparison, all in one process
  bit          prev_wr, prev_rd, addr_ok, prev_dqoe;
  int          wcnt, dcnt, ocnt, since_rd, cyc, last_start;
  logic [19:0] waddr;
  logic [7:0]  wdat;

  initial begin
    checks = 0; errors = 0;
    prev_wr = 0; prev_rd = 0; prev_dqoe = 0; addr_ok = 1;
    wcnt = 0; dcnt = 0; ocnt = 0; since_rd = 1000; cyc = 0; last_start = -1000;
    waddr = '0; wdat = '0;
    mem_dq_in = 8'h5A;
  end

  always @(negedge clk) begin
    bit sel, wr, rd, e_we, e_rd, e_dqoe, e_rdy, e_rsp;
    string tg;
    cyc = cyc + 1;
    sel = !mem_cs1_n && mem_cs2;
    wr  = sel && !mem_we_n;
    rd  = sel && mem_we_n && !mem_oe_n;

    if (sel && !(prev_wr || prev_rd)) begin
      chk((cyc - last_start) * TCLK >= NS_WC, "R4 cycle spacing", cyc - last_start, up(NS_WC));
      last_start = cyc;
    end

    if (wr) begin
      if (!prev_wr) begin wcnt = 0; dcnt = 0; waddr = mem_addr; addr_ok = 1; end
      wcnt = wcnt + 1;
      if (mem_addr != waddr) addr_ok = 0;
      if (mem_dq_oe) begin
        if (dcnt == 0 || mem_dq_out == wdat) dcnt = dcnt + 1; else dcnt = 1;
        wdat = mem_dq_out;
      end else dcnt = 0;
    end
    if (prev_wr && !wr) begin
      chk(wcnt == P, "R3 R9 write pulse cycles", wcnt, P);
      chk(wcnt * TCLK >= NS_AW && wcnt * TCLK >= NS_WP, "R3 write pulse ns", wcnt * TCLK, NS_AW);
      chk(dcnt * TCLK >= NS_DW, "R3 data setup", dcnt * TCLK, NS_DW);
      chk(addr_ok, "R3 address stable", addr_ok, 1);
      chk(mem_dq_oe, "R5 data hold cycle", mem_dq_oe, 1);
      smem[waddr[7:0]] = wdat;
    end

    if (rd) begin
      if (!prev_rd) ocnt = 0;
      ocnt = ocnt + 1;
      since_rd = 0;
      mem_dq_in = (ocnt * TCLK >= mx(NS_AA, NS_OE)) ? smem[mem_addr[7:0]] : 8'hEE;
    end else begin
      since_rd = since_rd + 1;
      mem_dq_in = 8'h5A;
    end
    if (prev_rd && !rd) chk(ocnt == Q, "R6 R9 read strobe cycles", ocnt, Q);
    if (mem_dq_oe && !prev_dqoe)
      chk(!rd && since_rd * TCLK >= NS_HZ, "R7 bus contention", since_rd * TCLK, NS_HZ);
    prev_wr = wr; prev_rd = rd; prev_dqoe = mem_dq_oe;

    // cycle-by-cycle comparison with the reference model
    e_we   = (kind == 1) && (j < P);
    e_rd   = (kind == 2) && (j < Q);
    e_dqoe = (kind == 1) && (j <= P);
    e_rdy  = exp_ready(kind, j);
    e_rsp  = (kind == 2) && (j == Q);
    tg = rst ? "R1" : "R2";
    chk(mem_cs1_n == !(e_we || e_rd) && mem_cs2 == (e_we || e_rd), tg, {mem_cs1_n, mem_cs2}, {!(e_we || e_rd), e_we || e_rd});
    chk(mem_we_n == !e_we, rst ? "R1" : "R3", mem_we_n, !e_we);
    chk(mem_oe_n == !e_rd, rst ? "R1" : "R6", mem_oe_n, !e_rd);
    chk(mem_dq_oe == e_dqoe, rst ? "R1" : "R5", mem_dq_oe, e_dqoe);
    chk(req_ready == e_rdy, rst ? "R1" : (kind == 2 ? "R7" : "R4"), req_ready, e_rdy);
    chk(rsp_valid == e_rsp, rst ? "R1" : "R6", rsp_valid, e_rsp);
    if (e_rsp) chk(rsp_rdata == m_exp, "R6 read data", rsp_rdata, m_exp);
    if (!rst && kind != 0) chk(mem_addr == m_addr, "R8 R10 address", mem_addr, m_addr);
    if (e_dqoe) chk(mem_dq_out == m_data, "R5 R8 write data", mem_dq_out, m_data);
  end

  task automatic offer(input bit w, input logic [19:0] a, input logic [7:0] d);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    done = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    @(negedge rst);
    repeat (3) @(negedge clk);
    offer(1'b1, 20'h12345, 8'hA5);   // write then read, same address
    offer(1'b0, 20'h12345, 8'h00);
    offer(1'b1, 20'h00077, 8'h3C);
    offer(1'b0, 20'h12345, 8'h11);
    offer(1'b1, 20'h00077, 8'hC3);   // read then write turnaround
    offer(1'b0, 20'h00077, 8'h22);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    offer(1'b0, 20'hFFFFF, 8'h00);   // never written
    offer(1'b1, 20'hFFFFF, 8'hFF);
    offer(1'b1, 20'h00000, 8'h00);   // write after write
    offer(1'b0, 20'hFFFFF, 8'h33);
    offer(1'b0, 20'h00000, 8'h44);
    req_valid = 1'b0;
    repeat (40) @(negedge clk);
    done = 1'b1;
  end

endmodule

module sram_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic done_a, done_b;
  int   checks_a, errors_a, checks_b, errors_b;
  int   wd_fail = 0;
  int   cycles  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sram_ctrl_lane #(.GRADE(0), .TCLK(5))  lane_fast (.clk(clk), .rst(rst), .done(done_a), .checks(checks_a), .errors(errors_a));
  sram_ctrl_lane #(.GRADE(1), .TCLK(10)) lane_slow (.clk(clk), .rst(rst), .done(done_b), .checks(checks_b), .errors(errors_b));

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  end

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    while (!(done_a && done_b) && cycles < WATCHDOG) @(negedge clk);
    if (!(done_a && done_b)) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("Simulation finished: %0d checks, %0d errors",
             checks_a + checks_b + wd_fail, errors_a + errors_b + wd_fail);
    $finish;
  end

endmodule